// File: doc/BRIEF.md
# UART Receive FIFO with Line Status and Interrupt Identification

This block sits between the receive shift register of a 16550-style UART and the register bus. Each character the shift register completes arrives with its parity, framing and break flags. The block queues up to sixteen such characters together with their flags. It detects a character that arrives when no slot is free and flags it as an overrun.

Software sees the block through a small set of read strobes and combinational read values: the head character, a line status byte, an interrupt identification byte and an auxiliary status byte that holds a sticky underrun flag. A data interrupt is raised once the fill level reaches a trigger level that software selects. Line-status conditions outrank that data interrupt. Clearing every interrupt enable turns the block into a polled device whose state is read from the line status byte.

Top module: `urx_fifo_irq`

## Requirements
- R1: Characters leave the queue in arrival order, and up to 16 are held. `rd_data` shows the head character and reads 00h when the queue is empty. A `rd_data_strobe` on a non-empty queue removes the head at the clock edge.
- R2: `lsr[0]` is 1 whenever at least one character is held. It becomes 1 in the cycle after a character enters an empty queue and returns to 0 once the queue has been drained.
- R3: A character that arrives while 16 are held, with no removal in the same cycle, is discarded and the stored characters are kept. The arrival sets `lsr[1]`, which stays set until an `rd_lsr_strobe`. If an overrun and a line status read happen in the same cycle, the overrun wins.
- R4: A `rd_data_strobe` on an empty queue leaves the read position unchanged and sets `xstat[7]`. That bit holds until an `rd_xstat_strobe`, and a new underrun in the same cycle wins over the clear. The other bits of `xstat` read 0.
- R5: `trig_sel` picks the data trigger level: 0 gives 1 entry, 1 gives 4, 2 gives 8 and 3 gives 14. The data condition is true while the fill count is at or above that level and false as soon as the count drops below it.
- R6: `iir` reads 06h when a line-status condition is pending, 04h when only the data condition is pending, and 01h otherwise. A line-status condition means any of `lsr[4:1]` is set. `irq` is 1 exactly when `iir` is not 01h.
- R7: Interrupts are reported only while `fifo_en`, `ien_data` and `ien_line` are all 1. Otherwise `iir` reads 01h and `irq` is 0; with both enables clear the block runs in polled mode.
- R8: `lsr[4]`, `lsr[3]` and `lsr[2]` show the break, framing and parity flags of the head character. They clear when an `rd_lsr_strobe` is seen while the queue is not empty, and they stay clear until that head character is removed. That strobe also clears `lsr[1]`.
- R9: `lsr[7]` is 1 while at least one held character carries any error flag. It returns to 0 once none remains.
- R10: `lsr[5]` equals `thr_empty`, and `lsr[6]` equals `thr_empty` AND `tsr_empty`.
- R11: A `fifo_clear` pulse empties the queue, drops any character arriving in the same cycle and clears `lsr[7]`. It leaves `lsr[1]` and `xstat[7]` untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A completed character is presented this cycle |
| rx_data | input | 8 | Character from the shift register |
| rx_par_err | input | 1 | Parity error flag for the character |
| rx_frm_err | input | 1 | Framing error flag for the character |
| rx_brk | input | 1 | Break flag for the character |
| fifo_en | input | 1 | Queue mode enable |
| trig_sel | input | 2 | Trigger level select |
| fifo_clear | input | 1 | One-cycle pulse that empties the queue |
| ien_data | input | 1 | Received-data interrupt enable |
| ien_line | input | 1 | Line-status interrupt enable |
| thr_empty | input | 1 | Transmit holding register is empty |
| tsr_empty | input | 1 | Transmit shift register is empty |
| rd_data_strobe | input | 1 | Read of the data register |
| rd_lsr_strobe | input | 1 | Read of the line status register |
| rd_xstat_strobe | input | 1 | Read of the auxiliary status register |
| rd_data | output | 8 | Head character |
| lsr | output | 8 | Line status byte |
| iir | output | 8 | Interrupt identification byte |
| xstat | output | 8 | Auxiliary status, bit 7 is the underrun flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong fill count or read position shows in the very next cycle: either `rd_data` no longer matches the head of the bench's own queue, or `lsr[0]` and the 04h identification switch at the wrong fill level. A head-acknowledge flag stuck high or low shows as error bits in `lsr[4:2]` that never clear, or that clear too early, and `iir` then flips between 06h and 04h at the wrong time. A miscounted error tally leaves `lsr[7]` wrong once the last flagged character drains. A lost sticky flag shows as `lsr[1]` or `xstat[7]` dropping before its own read strobe. Every output is compared in every cycle, so each of these faults is reported within one clock of the cycle in which it first changes an output.

// File: rtl/urx_pkg.sv
package urx_pkg;

    localparam int unsigned CHAR_W = 8;

    localparam logic [7:0] IIR_NONE = 8'h01;
    localparam logic [7:0] IIR_DATA = 8'h04;
    localparam logic [7:0] IIR_LINE = 8'h06;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_err_t;

    typedef struct packed {
        rx_err_t           err;
        logic [CHAR_W-1:0] data;
    } rx_ent_t;

    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/urx_store.sv
module urx_store
    import urx_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  rx_ent_t       in_ent,
    input  logic          pop_req,
    output rx_ent_t       head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          err_any,
    output logic          pop,
    output logic          ovr_evt,
    output logic          und_evt
);

    rx_ent_t       mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt, ecnt;
    logic          full, do_push;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign pop     = pop_req & ~empty & ~flush;
    assign und_evt = pop_req & empty;
    assign do_push = push & ~flush & (~full | pop);
    assign ovr_evt = push & ~flush & full & ~pop;

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= in_ent;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
            ecnt <= '0;
        end else begin
            if (do_push) wptr <= nxt(wptr);
            if (pop)     rptr <= nxt(rptr);
            cnt  <= cnt + CW'(do_push) - CW'(pop);
            ecnt <= ecnt + CW'(do_push & (|in_ent.err))
                         - CW'(pop & (|mem[rptr].err));
        end
    end

    assign head    = empty ? '0 : mem[rptr];
    assign count   = cnt;
    assign err_any = (ecnt != '0);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    p_ovr_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        ovr_evt |=> cnt == $past(cnt));

    p_underrun_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (und_evt && !flush) |=> rptr == $past(rptr));

endmodule

// File: rtl/urx_status.sv
module urx_status
    import urx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       pop,
    input  logic       ovr_evt,
    input  logic       und_evt,
    input  logic       rd_lsr,
    input  logic       rd_und,
    input  logic       empty,
    input  rx_err_t    head_err,
    input  logic       err_any,
    input  logic       thr_empty,
    input  logic       tsr_empty,
    output logic [7:0] lsr,
    output logic [7:0] und_stat
);

    logic    ovr_st, und_st, hd_ack;
    rx_err_t shown;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_st <= 1'b0;
            und_st <= 1'b0;
            hd_ack <= 1'b0;
        end else begin
            ovr_st <= ovr_evt | (ovr_st & ~rd_lsr);
            und_st <= und_evt | (und_st & ~rd_und);
            if (flush || pop)          hd_ack <= 1'b0;
            else if (rd_lsr && !empty) hd_ack <= 1'b1;
        end
    end

    assign shown    = (empty || hd_ack) ? '0 : head_err;
    assign lsr      = {err_any, thr_empty & tsr_empty, thr_empty,
                       shown.brk, shown.frm, shown.par, ovr_st, ~empty};
    assign und_stat = {und_st, 7'b0};

    p_und_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        und_evt |=> und_stat[7]);

    p_lsr_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && !ovr_evt && !empty && !pop && !flush) |=> lsr[4:1] == 4'b0);

endmodule

// File: rtl/urx_irq.sv
module urx_irq
    import urx_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          fifo_en,
    input  logic          ien_data,
    input  logic          ien_line,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] count,
    input  logic [3:0]    line_err,
    output logic [7:0]    iir,
    output logic          irq
);

    logic active, line_pend, data_pend;

    assign active    = fifo_en & ien_data & ien_line;
    assign line_pend = |line_err;
    assign data_pend = 32'(count) >= trig_level(trig_sel);

    always_comb begin
        if (active && line_pend)      iir = IIR_LINE;
        else if (active && data_pend) iir = IIR_DATA;
        else                          iir = IIR_NONE;
    end

    assign irq = (iir != IIR_NONE);

endmodule

// File: rtl/urx_fifo_irq.sv
module urx_fifo_irq
    import urx_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_par_err,
    input  logic       rx_frm_err,
    input  logic       rx_brk,
    input  logic       fifo_en,
    input  logic [1:0] trig_sel,
    input  logic       fifo_clear,
    input  logic       ien_data,
    input  logic       ien_line,
    input  logic       thr_empty,
    input  logic       tsr_empty,
    input  logic       rd_data_strobe,
    input  logic       rd_lsr_strobe,
    input  logic       rd_xstat_strobe,
    output logic [7:0] rd_data,
    output logic [7:0] lsr,
    output logic [7:0] iir,
    output logic [7:0] xstat,
    output logic       irq
);

    rx_ent_t       in_ent, head;
    logic [CW-1:0] count;
    logic          empty, err_any, pop, ovr_evt, und_evt;

    assign in_ent.data    = rx_data;
    assign in_ent.err.brk = rx_brk;
    assign in_ent.err.frm = rx_frm_err;
    assign in_ent.err.par = rx_par_err;

    urx_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (fifo_clear),
        .push    (rx_valid),
        .in_ent  (in_ent),
        .pop_req (rd_data_strobe),
        .head    (head),
        .count   (count),
        .empty   (empty),
        .err_any (err_any),
        .pop     (pop),
        .ovr_evt (ovr_evt),
        .und_evt (und_evt)
    );

    urx_status u_status (
        .clk       (clk),
        .rst       (rst),
        .flush     (fifo_clear),
        .pop       (pop),
        .ovr_evt   (ovr_evt),
        .und_evt   (und_evt),
        .rd_lsr    (rd_lsr_strobe),
        .rd_und    (rd_xstat_strobe),
        .empty     (empty),
        .head_err  (head.err),
        .err_any   (err_any),
        .thr_empty (thr_empty),
        .tsr_empty (tsr_empty),
        .lsr       (lsr),
        .und_stat  (xstat)
    );

    urx_irq #(.CW(CW)) u_irq (
        .fifo_en  (fifo_en),
        .ien_data (ien_data),
        .ien_line (ien_line),
        .trig_sel (trig_sel),
        .count    (count),
        .line_err (lsr[4:1]),
        .iir      (iir),
        .irq      (irq)
    );

    assign rd_data = head.data;

    p_dr_set_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !fifo_clear && !lsr[0]) |=> lsr[0]);

    p_line_over_data_r6: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && ien_data && ien_line && lsr[1]) |-> iir == 8'h06);

    p_gated_r7: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en || !ien_data || !ien_line) |-> !irq);

    p_flush_r11: assert property (@(posedge clk) disable iff (rst)
        fifo_clear |=> (!lsr[0] && !lsr[7]));

endmodule

// File: tb/urx_fifo_irq_tb.sv
module urx_fifo_irq_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       rx_valid = 0, rx_par_err = 0, rx_frm_err = 0, rx_brk = 0;
    logic [7:0] rx_data = 0;
    logic       fifo_en = 1, fifo_clear = 0, ien_data = 1, ien_line = 1;
    logic [1:0] trig_sel = 0;
    logic       thr_empty = 1, tsr_empty = 1;
    logic       rd_data_strobe = 0, rd_lsr_strobe = 0, rd_xstat_strobe = 0;
    logic [7:0] rd_data, lsr, iir, xstat;
    logic       irq;

    urx_fifo_irq u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
        .fifo_en(fifo_en), .trig_sel(trig_sel), .fifo_clear(fifo_clear),
        .ien_data(ien_data), .ien_line(ien_line), .thr_empty(thr_empty),
        .tsr_empty(tsr_empty), .rd_data_strobe(rd_data_strobe),
        .rd_lsr_strobe(rd_lsr_strobe), .rd_xstat_strobe(rd_xstat_strobe),
        .rd_data(rd_data), .lsr(lsr), .iir(iir), .xstat(xstat), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model: entry = {brk, frm, par, data}
    logic [10:0] mq[$];
    bit m_ack = 0, m_ovr = 0, m_und = 0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int tlev(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [7:0] exp_lsr();
        logic [7:0] v = '0;
        v[0] = (mq.size() != 0);
        v[1] = m_ovr;
        if (mq.size() != 0 && !m_ack) v[4:2] = mq[0][10:8];
        v[5] = thr_empty;
        v[6] = thr_empty & tsr_empty;
        foreach (mq[i]) if (mq[i][10:8] != 3'b0) v[7] = 1'b1;
        return v;
    endfunction

    function automatic logic [7:0] exp_iir();
        logic [7:0] l = exp_lsr();
        bit act = fifo_en & ien_data & ien_line;
        if (act && l[4:1] != 4'b0) return 8'h06;
        if (act && mq.size() >= tlev(trig_sel)) return 8'h04;
        return 8'h01;
    endfunction

    task automatic model();
        bit emp = (mq.size() == 0);
        int sz = mq.size();
        bit pp = rd_data_strobe && !emp && !fifo_clear;
        if (rd_data_strobe && emp) m_und = 1;
        else if (rd_xstat_strobe) m_und = 0;
        if (rx_valid && !fifo_clear && sz == 16 && !pp) m_ovr = 1;
        else if (rd_lsr_strobe) m_ovr = 0;
        if (fifo_clear || pp) m_ack = 0;
        else if (rd_lsr_strobe && !emp) m_ack = 1;
        if (fifo_clear) mq.delete();
        else begin
            if (pp) void'(mq.pop_front());
            if (rx_valid && (sz < 16 || pp))
                mq.push_back({rx_brk, rx_frm_err, rx_par_err, rx_data});
        end
    endtask

    task automatic check_all();
        logic [7:0] l = exp_lsr();
        logic [7:0] ei = exp_iir();
        chk("R1 rd_data", rd_data, mq.size() != 0 ? mq[0][7:0] : 8'h00);
        chk("R2 lsr0", {7'b0, lsr[0]}, {7'b0, l[0]});
        chk("R3 lsr1", {7'b0, lsr[1]}, {7'b0, l[1]});
        chk("R8 lsr4_2", {5'b0, lsr[4:2]}, {5'b0, l[4:2]});
        chk("R9 lsr7", {7'b0, lsr[7]}, {7'b0, l[7]});
        chk("R10 lsr6_5", {6'b0, lsr[6:5]}, {6'b0, l[6:5]});
        chk("R4 xstat", xstat, {m_und, 7'b0});
        chk("R5 R6 R7 iir", iir, ei);
        chk("R6 irq", {7'b0, irq}, {7'b0, ei != 8'h01});
    endtask

    task automatic step();
        @(posedge clk);
        model();
        @(negedge clk);
        check_all();
        rx_valid = 0; rx_par_err = 0; rx_frm_err = 0; rx_brk = 0;
        rd_data_strobe = 0; rd_lsr_strobe = 0; rd_xstat_strobe = 0;
        fifo_clear = 0;
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] e);
        rx_valid = 1; rx_data = d;
        {rx_brk, rx_frm_err, rx_par_err} = e;
        step();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset lsr R10", lsr, 8'h60);
        chk("reset iir R6", iir, 8'h01);
        chk("reset xstat R4", xstat, 8'h00);
        chk("reset rd_data R1", rd_data, 8'h00);

        // R5: trigger level 4
        trig_sel = 2'd1;
        for (int i = 0; i < 3; i++) push(8'h30 + 8'(i), 3'b0);
        chk("R5 below trigger", iir, 8'h01);
        push(8'h33, 3'b0);
        chk("R5 at trigger", iir, 8'h04);
        rd_data_strobe = 1; step();
        chk("R5 below again", iir, 8'h01);
        // R7: gating
        trig_sel = 2'd0;
        ien_line = 0; step();
        chk("R7 gated iir", iir, 8'h01);
        chk("R7 gated irq", {7'b0, irq}, 8'h00);
        ien_line = 1;

        // R11: flush with a flagged entry
        push(8'h5A, 3'b100);
        fifo_clear = 1; step();
        chk("R11 empty after clear", {7'b0, lsr[0]}, 8'h00);
        chk("R11 err-in-fifo cleared", {7'b0, lsr[7]}, 8'h00);

        // R3: fill, then overrun
        for (int i = 0; i < 16; i++) push(8'h10 + 8'(i), 3'b0);
        push(8'hAA, 3'b0);
        chk("R3 overrun flag", {7'b0, lsr[1]}, 8'h01);
        chk("R3 head kept", rd_data, 8'h10);
        chk("R6 line over data", iir, 8'h06);
        rd_lsr_strobe = 1; step();
        chk("R3 cleared by lsr read", {7'b0, lsr[1]}, 8'h00);
        fifo_clear = 1; step();

        // R8 / R6: error at head
        push(8'h77, 3'b001);
        chk("R8 parity at head", {5'b0, lsr[4:2]}, 8'h01);
        chk("R9 error present", {7'b0, lsr[7]}, 8'h01);
        chk("R6 line id", iir, 8'h06);
        rd_lsr_strobe = 1; step();
        chk("R8 cleared by read", {5'b0, lsr[4:2]}, 8'h00);
        chk("R6 data id after ack", iir, 8'h04);
        rd_data_strobe = 1; step();
        chk("R9 error gone", {7'b0, lsr[7]}, 8'h00);

        // R4: underrun
        rd_data_strobe = 1; step();
        chk("R4 underrun set", xstat, 8'h80);
        chk("R4 data on empty", rd_data, 8'h00);
        push(8'h41, 3'b0);
        chk("R4 pointer held", rd_data, 8'h41);
        rd_xstat_strobe = 1; step();
        chk("R4 underrun cleared", xstat, 8'h00);

        // random phases
        for (int ph = 0; ph < 12; ph++) begin
            int pp = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 30 : 55;
            int pr = (ph % 3 == 0) ? 25 : (ph % 3 == 1) ? 75 : 50;
            trig_sel  = 2'($urandom_range(0, 3));
            ien_data  = ($urandom_range(0, 9) != 0);
            ien_line  = ($urandom_range(0, 9) != 0);
            fifo_en   = ($urandom_range(0, 9) != 0);
            for (int c = 0; c < 350; c++) begin
                rx_valid        = ($urandom_range(0, 99) < pp);
                rx_data         = 8'($urandom);
                rx_par_err      = ($urandom_range(0, 7) == 0);
                rx_frm_err      = ($urandom_range(0, 7) == 0);
                rx_brk          = ($urandom_range(0, 15) == 0);
                rd_data_strobe  = ($urandom_range(0, 99) < pr);
                rd_lsr_strobe   = ($urandom_range(0, 9) == 0);
                rd_xstat_strobe = ($urandom_range(0, 19) == 0);
                fifo_clear      = ($urandom_range(0, 149) == 0);
                thr_empty       = ($urandom_range(0, 3) != 0);
                tsr_empty       = ($urandom_range(0, 1) != 0);
                step();
            end
        end
        finish_run();
    end

endmodule